// File: doc/BRIEF.md
# Module clock enable controller

This block decides, for each of eight peripheral modules, whether that module's functional clock and its interface clock may run. It sends those decisions as registered gate-enable levels to external clock gating cells. Software programs two independent enable registers over a small register bus. Hardware can still hold a clock on: a module's clock request keeps the matching clock alive after software clears its bit. A wakeup event from a module forces that module's functional clock on with no software action. Each module drives several functional clock enables, all copies of the same decision.

The two lowest module positions belong to subsystems managed by hardware alone. They have no software enable. Their clocks follow their request and wakeup inputs, and reading their register positions returns the present hardware-driven gate state. A module whose interface clock is gated is reported idle to the interconnect, even if its functional clock is still running.

Top module: `modclk_enable_ctrl`

## Requirements
- R1: The functional enable register (byte offset 0x0, bit m = module m) and the interface enable register (byte offset 0x4, bit m = module m) are written independently. A write to one leaves the other unchanged.
- R2: Setting a software enable bit turns on the matching gate output at the same clock edge that performs the write.
- R3: When a module's functional software bit is clear, its functional enable is on in the cycle after its functional request or wakeup is high. It is off in the cycle after all three are low.
- R4: A high wakeup input turns the module's functional enables on at the next edge, whatever its software bit holds.
- R5: Modules 0 and 1 are hardware-managed. Writes to bits 0 and 1 of either register have no effect. Their functional enable is the registered OR of request and wakeup, and their interface enable is the registered request.
- R6: The idle output bit m is high exactly when the interface enable of module m is low, independent of the functional enable.
- R7: Each module has FCLK_PER_MOD functional enable outputs, at indices m*FCLK_PER_MOD+k, and all of them carry the same value in every cycle.
- R8: While reset is asserted, all software bits are zero, the hardware-managed modules' functional and interface enables are on, every other enable is off, and the read data is zero.
- R9: A read (select high, write low) latches its result into the read data at the next edge. Offset 0x0 and offset 0x4 return the software bits in bits 7..2 and the current gate state in bits 1..0. All upper bits read as zero, and any other offset reads as zero.
- R10: A module's interface enable is on in the cycle after its software bit or its interface request is high, and off in the cycle after both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fclk_req | input | 8 | Per-module functional clock request |
| iclk_req | input | 8 | Per-module interface clock request |
| wakeup | input | 8 | Per-module wakeup event |
| fclk_en | output | 16 | Functional gate enables, FCLK_PER_MOD per module |
| iclk_en | output | 8 | Interface gate enables |
| iface_idle | output | 8 | Module idle as seen by the interconnect |

## Verification
The assertions assume that request, wakeup and bus inputs are synchronous to the controller clock and hold stable between rising edges. They also assume that bus signals carry no unknown values while the strobe is high. The bench keeps to this by changing every input only on the falling edge. It raises the strobe for one cycle per access and drives zeros on idle cycles. Expected outputs come from a small register-level reference kept in the bench, and each is compared one edge after the stimulus that caused it.

// File: rtl/modclk_pkg.sv
package modclk_pkg;

  localparam int unsigned OFS_FUNC  = 0;
  localparam int unsigned OFS_IFACE = 4;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_FUNC  = 2'd1,
    SEL_IFACE = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/modclk_rst_sync.sv
module modclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/modclk_regs.sv
module modclk_regs
  import modclk_pkg::*;
#(
  parameter int NUM_MOD = 8,
  parameter int NUM_HW  = 2,
  parameter int ADDR_W  = 4,
  parameter int BUS_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  input  logic [NUM_MOD-1:0] f_state_i,
  input  logic [NUM_MOD-1:0] i_state_i,
  output logic [NUM_MOD-1:0] f_sw_eff_o,
  output logic [NUM_MOD-1:0] i_sw_eff_o,
  output logic [BUS_W-1:0]   bus_rdata
);

  localparam logic [NUM_MOD-1:0] HW_MASK = NUM_MOD'((1 << NUM_HW) - 1);
  localparam logic [NUM_MOD-1:0] SW_MASK = ~HW_MASK;
  localparam int                 PAD_W   = BUS_W - NUM_MOD;

  reg_sel_e            sel;
  logic                wr_f, wr_i, rd_en;
  logic [NUM_MOD-1:0]  f_sw_q, f_sw_d;
  logic [NUM_MOD-1:0]  i_sw_q, i_sw_d;
  logic [NUM_MOD-1:0]  rd_field;
  logic [BUS_W-1:0]    rdata_q, rdata_d;
  logic                unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:NUM_MOD];

  // address decode
  always_comb begin
    if (bus_addr == ADDR_W'(OFS_FUNC)) begin
      sel = SEL_FUNC;
    end else if (bus_addr == ADDR_W'(OFS_IFACE)) begin
      sel = SEL_IFACE;
    end else begin
      sel = SEL_NONE;
    end
  end

  assign wr_f  = bus_sel && bus_wr && (sel == SEL_FUNC);
  assign wr_i  = bus_sel && bus_wr && (sel == SEL_IFACE);
  assign rd_en = bus_sel && !bus_wr;

  // next state with write bypass so a set bit acts at the write edge
  always_comb begin
    f_sw_d = wr_f ? (bus_wdata[NUM_MOD-1:0] & SW_MASK) : f_sw_q;
    i_sw_d = wr_i ? (bus_wdata[NUM_MOD-1:0] & SW_MASK) : i_sw_q;
  end

  assign f_sw_eff_o = f_sw_d;
  assign i_sw_eff_o = i_sw_d;

  // read path: software bits where writable, gate state elsewhere
  always_comb begin
    unique case (sel)
      SEL_FUNC:  rd_field = (f_sw_q & SW_MASK) | (f_state_i & HW_MASK);
      SEL_IFACE: rd_field = (i_sw_q & SW_MASK) | (i_state_i & HW_MASK);
      default:   rd_field = '0;
    endcase
    rdata_d = {{PAD_W{1'b0}}, rd_field};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_sw_q <= '0;
    end else if (wr_f) begin
      f_sw_q <= f_sw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_sw_q <= '0;
    end else if (wr_i) begin
      i_sw_q <= i_sw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  assert_indep_iface_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_f |=> $stable(i_sw_q));
  assert_indep_func_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> $stable(f_sw_q));
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (sel == SEL_NONE)) |=> (bus_rdata == '0));
  assert_no_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(bus_rdata));

endmodule

// File: rtl/modclk_lane.sv
module modclk_lane #(
  parameter bit HW_MANAGED = 1'b0,
  parameter int FPM        = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           f_sw_i,
  input  logic           i_sw_i,
  input  logic           fclk_req_i,
  input  logic           iclk_req_i,
  input  logic           wake_i,
  output logic [FPM-1:0] fclk_en_o,
  output logic           iclk_en_o,
  output logic           idle_o
);

  localparam logic RST_ON = HW_MANAGED;

  logic           f_next, i_next;
  logic [FPM-1:0] f_q;
  logic           i_q;

  always_comb begin
    f_next = f_sw_i | fclk_req_i | wake_i;
    i_next = i_sw_i | iclk_req_i;
  end

  // one flop per functional copy, each near its gating cell
  for (genvar k = 0; k < FPM; k++) begin : g_fcopy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q[k] <= RST_ON;
      end else begin
        f_q[k] <= f_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q <= RST_ON;
    end else begin
      i_q <= i_next;
    end
  end

  assign fclk_en_o = f_q;
  assign iclk_en_o = i_q;
  assign idle_o    = ~i_q;

  assert_set_immediate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    f_sw_i |=> f_q[0]);
  assert_req_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fclk_req_i |=> f_q[0]);
  assert_clear_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_sw_i && !fclk_req_i && !wake_i) |=> !f_q[0]);
  assert_wake_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |=> f_q[0]);
  assert_iclk_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (i_sw_i || iclk_req_i) |=> iclk_en_o);
  assert_iclk_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!i_sw_i && !iclk_req_i) |=> !iclk_en_o);

endmodule

// File: rtl/modclk_enable_ctrl.sv
module modclk_enable_ctrl
  import modclk_pkg::*;
#(
  parameter int NUM_MOD      = 8,
  parameter int NUM_HW       = 2,
  parameter int FCLK_PER_MOD = 2,
  parameter int ADDR_W       = 4,
  parameter int BUS_W        = 32,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_sel,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [BUS_W-1:0]                bus_wdata,
  output logic [BUS_W-1:0]                bus_rdata,
  input  logic [NUM_MOD-1:0]              fclk_req,
  input  logic [NUM_MOD-1:0]              iclk_req,
  input  logic [NUM_MOD-1:0]              wakeup,
  output logic [NUM_MOD*FCLK_PER_MOD-1:0] fclk_en,
  output logic [NUM_MOD-1:0]              iclk_en,
  output logic [NUM_MOD-1:0]              iface_idle
);

  logic               rst_n_s;
  logic [NUM_MOD-1:0] f_sw_eff, i_sw_eff;
  logic [NUM_MOD-1:0] f_state;

  modclk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  modclk_regs #(
    .NUM_MOD (NUM_MOD),
    .NUM_HW  (NUM_HW),
    .ADDR_W  (ADDR_W),
    .BUS_W   (BUS_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .f_state_i  (f_state),
    .i_state_i  (iclk_en),
    .f_sw_eff_o (f_sw_eff),
    .i_sw_eff_o (i_sw_eff),
    .bus_rdata  (bus_rdata)
  );

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    modclk_lane #(
      .HW_MANAGED (m < NUM_HW),
      .FPM        (FCLK_PER_MOD)
    ) u_lane (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .f_sw_i     (f_sw_eff[m]),
      .i_sw_i     (i_sw_eff[m]),
      .fclk_req_i (fclk_req[m]),
      .iclk_req_i (iclk_req[m]),
      .wake_i     (wakeup[m]),
      .fclk_en_o  (fclk_en[m*FCLK_PER_MOD +: FCLK_PER_MOD]),
      .iclk_en_o  (iclk_en[m]),
      .idle_o     (iface_idle[m])
    );

    assign f_state[m] = fclk_en[m*FCLK_PER_MOD];

    for (genvar k = 1; k < FCLK_PER_MOD; k++) begin : g_fan
      assert_copies_match_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
        fclk_en[m*FCLK_PER_MOD+k] == fclk_en[m*FCLK_PER_MOD]);
    end

    if (m < NUM_HW) begin : g_hw_chk
      assert_hw_only_off_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
        (!fclk_req[m] && !wakeup[m]) |=> !fclk_en[m*FCLK_PER_MOD]);
      assert_hw_iface_off_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
        !iclk_req[m] |=> !iclk_en[m]);
    end
  end

endmodule

// File: tb/modclk_enable_ctrl_test.sv
`timescale 1ns/1ps
module modclk_enable_ctrl_test;

  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  fclk_req, iclk_req, wakeup;
  logic [15:0] fclk_en;
  logic [7:0]  iclk_en, iface_idle;

  modclk_enable_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fclk_req(fclk_req), .iclk_req(iclk_req), .wakeup(wakeup),
    .fclk_en(fclk_en), .iclk_en(iclk_en), .iface_idle(iface_idle)
  );

  typedef struct {
    string       tag;
    logic [15:0] f;
    logic [7:0]  i;
    logic [31:0] rd;
    bit          chk_rd;
    int          due;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  logic [7:0] sf = 0, si = 0, mf = 0, mi = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] spread(input logic [7:0] v);
    logic [15:0] r;
    for (int m = 0; m < 8; m++) begin
      r[2*m]   = v[m];
      r[2*m+1] = v[m];
    end
    return r;
  endfunction

  task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the item due this cycle and compares it
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " fclk_en R7"}, fclk_en === e.f, {16'h0, fclk_en}, {16'h0, e.f});
      check({e.tag, " iclk_en"}, iclk_en === e.i, {24'h0, iclk_en}, {24'h0, e.i});
      check({e.tag, " idle R6"}, iface_idle === ~e.i, {24'h0, iface_idle}, {24'h0, ~e.i});
      if (e.chk_rd)
        check({e.tag, " rdata R9"}, bus_rdata === e.rd, bus_rdata, e.rd);
    end
  end

  // driver: one cycle of stimulus, expected result pushed for the next edge
  task automatic drive(input string tag, input bit wr, input bit rd, input logic [3:0] a,
                       input logic [31:0] wd, input logic [7:0] fr, input logic [7:0] ir,
                       input logic [7:0] wk);
    exp_t e;
    @(negedge clk);
    bus_sel   = wr | rd;
    bus_wr    = wr;
    bus_addr  = a;
    bus_wdata = wd;
    fclk_req  = fr;
    iclk_req  = ir;
    wakeup    = wk;
    e.tag    = tag;
    e.chk_rd = rd;
    if (a == 4'h0)      e.rd = {24'h0, (sf & 8'hFC) | (mf & 8'h03)};
    else if (a == 4'h4) e.rd = {24'h0, (si & 8'hFC) | (mi & 8'h03)};
    else                e.rd = 32'h0;
    if (wr && a == 4'h0) sf = wd[7:0] & 8'hFC;
    if (wr && a == 4'h4) si = wd[7:0] & 8'hFC;
    mf = sf | fr | wk;
    mi = si | ir;
    e.f   = spread(mf);
    e.i   = mi;
    e.due = cyc + 1;
    q.push_back(e);
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rst_n = 1'b0;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    fclk_req = 0; iclk_req = 0; wakeup = 0;
    repeat (3) @(negedge clk);
    check("reset fclk R8", fclk_en === 16'h000F, {16'h0, fclk_en}, 32'h000F);
    check("reset iclk R8", iclk_en === 8'h03, {24'h0, iclk_en}, 32'h03);
    check("reset idle R8", iface_idle === 8'hFC, {24'h0, iface_idle}, 32'hFC);
    check("reset rdata R8", bus_rdata === 32'h0, bus_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mf = 0; mi = 0;

    drive("R8 sw func cleared", 0, 1, 4'h0, 0, 0, 0, 0);
    drive("R8 sw iface cleared", 0, 1, 4'h4, 0, 0, 0, 0);
    drive("R2 R5 set all func", 1, 0, 4'h0, 32'hFFFF_FFFF, 0, 0, 0);
    drive("R9 read func", 0, 1, 4'h0, 0, 0, 0, 0);
    drive("R1 iface untouched", 0, 1, 4'h4, 0, 0, 0, 0);
    drive("R10 R2 set iface", 1, 0, 4'h4, 32'h30, 0, 0, 0);
    drive("R1 func untouched", 0, 1, 4'h0, 0, 0, 0, 0);
    drive("R5 hw req", 0, 0, 4'h0, 0, 8'h01, 0, 0);
    drive("R5 hw state readback", 0, 1, 4'h0, 0, 8'h01, 0, 0);
    drive("R5 hw wake", 0, 0, 4'h0, 0, 0, 0, 8'h02);
    drive("R5 hw idle", 0, 0, 4'h0, 0, 0, 0, 0);
    drive("R3 clear with req", 1, 0, 4'h0, 32'h0, 8'h10, 0, 0);
    drive("R3 req drop", 0, 0, 4'h0, 0, 0, 0, 0);
    drive("R4 wake forces", 0, 0, 4'h0, 0, 0, 0, 8'h40);
    drive("R4 wake held", 0, 0, 4'h0, 0, 8'h40, 0, 0);
    drive("R3 all drop", 0, 0, 4'h0, 0, 0, 0, 0);
    drive("R10 clear with req", 1, 0, 4'h4, 32'h0, 0, 8'h20, 0);
    drive("R10 req drop", 0, 0, 4'h0, 0, 0, 0, 0);
    drive("R5 iface hw write", 1, 0, 4'h4, 32'h03, 0, 0, 0);
    drive("R5 iface hw read", 0, 1, 4'h4, 0, 0, 0, 0);
    drive("R5 hw iface req", 0, 0, 4'h0, 0, 0, 8'h02, 0);
    drive("R9 unmapped write", 1, 0, 4'h8, 32'hFF, 0, 0, 0);
    drive("R9 unmapped read", 0, 1, 4'h8, 0, 0, 0, 0);
    drive("R9 func after unmapped", 0, 1, 4'h0, 0, 0, 0, 0);
    drive("R6 func on iface off", 1, 0, 4'h0, 32'h80, 0, 0, 0);
    drive("R6 iface on", 1, 0, 4'h4, 32'h84, 0, 0, 0);
    drive("R1 R9 iface read", 0, 1, 4'h4, 0, 0, 0, 0);
    drive("R9 func read", 0, 1, 4'h0, 0, 0, 0, 0);
    drive("R3 mixed", 0, 0, 4'h0, 0, 8'h0C, 8'h41, 8'h20);
    drive("idle", 0, 0, 4'h0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("scoreboard drained", q.size() == 0, q.size(), 0);
    report();
  end

endmodule